// File: doc/BRIEF.md
# Bandwidth-Limited Commit Head Controller

This block decides, each cycle, which entries at the head of a reorder buffer leave it. The buffer presents a window of `SLOTS` head entries in program order. Each entry has a ready bit, a set of class flags and a sequence number. The controller walks that window from the oldest entry. It retires ordinary executed instructions until `WIDTH` of them have retired in the cycle. Squashed entries are drained along the way and do not use up that bandwidth.

Entries that cannot simply retire end the walk. An unexecuted serialising instruction is returned to the execute stage as a non-speculative request. An unexecuted load is returned as an uncached access. A faulting instruction raises a trap request. An unexecuted entry of no known class raises an error flag. Serialising instructions and faults go out only when they are the first commit of the cycle and no store is still waiting to write back; otherwise the walk stalls on them.

The block also keeps the committed program counter, the sequence number of the youngest committed instruction, a running count of committed instructions and a count of cycles that used the full commit bandwidth. While a trap is outstanding, nothing retires until the trap is cleared.

Top module: `commit_head_ctrl`

## Requirements
- R1: Slots are examined in order from slot 0. The walk ends at the first slot whose ready bit is low, or once `WIDTH` non-squashed instructions have retired in the cycle. A normal head is executed (flag bit 1 set) and has no other special bit set.
- R2: A ready head with the squashed flag (bit 0) set retires at once and does not count toward `WIDTH`. A squashed head found after `WIDTH` retirements is not retired.
- R3: An unexecuted head (bit 1 clear) with any serialising flag set ends the walk. The serialising flags are non-speculative (bit 3), store-conditional (bit 4), memory barrier (bit 5) and write barrier (bit 6). If that head is the first commit of the cycle and `store_wb_pending_i` is low, `nonspec_req_o` rises with the head's sequence number and `clear_cancommit_o` marks that slot. Otherwise no request is made and nothing past it retires.
- R4: An unexecuted load (bit 7) with no serialising flag is sent back with `nonspec_req_o`, `nonspec_uncached_o` and `clear_cancommit_o` set, at any position in the window and regardless of pending stores, and the walk ends.
- R5: An executed head with the fault flag (bit 2) never retires. It raises `trap_req_o` with its sequence number only when it is the first commit of the cycle and no stores are pending. From the next cycle `trap_pending_o` is high.
- R6: Every non-squashed retire advances `pc_o` by `INST_BYTES` (4). At the next edge, `done_seq_o` takes the sequence number of the youngest instruction retired in the cycle.
- R7: `commit_count_o` grows by the number of non-squashed retires, excluding heads marked nop (bit 8) or instruction prefetch (bit 9).
- R8: `bw_limit_events_o` increments after every cycle in which exactly `WIDTH` non-squashed instructions retired.
- R9: While `trap_pending_o` is high, nothing retires and no request is raised. A cycle with `trap_clear_i` high drops the flag at the next edge. `trap_clear_i` has no effect while no trap is pending.
- R10: An unexecuted head with none of the serialising or load flags raises `error_o` and ends the walk without retiring it.
- R11: After reset, `pc_o` equals `RESET_PC`, and `done_seq_o`, both counters and `trap_pending_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| head_ready_i | input | SLOTS | Per-slot head-is-ready bit, slot 0 oldest |
| head_flags_i | input | SLOTS*10 | Per-slot class flags, slot i at bits [10i+9:10i] |
| head_seq_i | input | SLOTS*SEQ_W | Per-slot sequence number |
| store_wb_pending_i | input | 1 | At least one store still awaits writeback |
| trap_clear_i | input | 1 | The outstanding trap has been handled |
| retire_o | output | SLOTS | Slots removed from the buffer this cycle |
| clear_cancommit_o | output | SLOTS | Slot whose can-commit bit must be cleared |
| nonspec_req_o | output | 1 | Request to execute a head non-speculatively |
| nonspec_uncached_o | output | 1 | The request is an uncached load |
| nonspec_seq_o | output | SEQ_W | Sequence number of the requested head |
| trap_req_o | output | 1 | A faulting head takes its trap |
| trap_seq_o | output | SEQ_W | Sequence number of the faulting head |
| error_o | output | 1 | Unexecuted head of unknown class |
| trap_pending_o | output | 1 | Trap raised and not yet cleared |
| pc_o | output | PC_W | Committed program counter |
| done_seq_o | output | SEQ_W | Youngest committed sequence number |
| commit_count_o | output | CNT_W | Committed instructions, nops and prefetches excluded |
| bw_limit_events_o | output | CNT_W | Cycles that used the full commit width |

## Verification
Ordinary retirement and a special action can occur in the same cycle. The most telling case puts a normal head in slot 0 and a serialising, faulting or uncached-load head behind it. The bench builds these windows and also varies the store-pending input. It expects slot 0 to retire and the serialising or faulting head to stall without a request, while the uncached load still produces its request. A squashed entry ahead of a serialising head checks the same overlap the other way round: the drained entry must not count as a commit, so the request still goes out.

// File: rtl/commit_pkg.sv
package commit_pkg;

    localparam int FLAG_W     = 10;
    localparam int F_SQUASHED = 0;
    localparam int F_EXECUTED = 1;
    localparam int F_FAULT    = 2;
    localparam int F_NONSPEC  = 3;
    localparam int F_STCOND   = 4;
    localparam int F_MEMBAR   = 5;
    localparam int F_WRBAR    = 6;
    localparam int F_LOAD     = 7;
    localparam int F_NOP      = 8;
    localparam int F_IPREF    = 9;

    typedef enum logic [2:0] {
        K_RETIRE,
        K_SQUASHED,
        K_SERIAL,
        K_UNCACHED,
        K_FAULT,
        K_UNKNOWN
    } head_kind_e;

endpackage

// File: rtl/head_classify.sv
module head_classify
    import commit_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_i,
    output head_kind_e        kind_o,
    output logic              countable_o
);

    logic serialising;

    always_comb begin
        serialising = flags_i[F_NONSPEC] | flags_i[F_STCOND] |
                      flags_i[F_MEMBAR]  | flags_i[F_WRBAR];
        countable_o = !(flags_i[F_NOP] | flags_i[F_IPREF]);
        if (flags_i[F_SQUASHED]) begin
            kind_o = K_SQUASHED;
        end else if (!flags_i[F_EXECUTED]) begin
            if (serialising) begin
                kind_o = K_SERIAL;
            end else if (flags_i[F_LOAD]) begin
                kind_o = K_UNCACHED;
            end else begin
                kind_o = K_UNKNOWN;
            end
        end else if (flags_i[F_FAULT]) begin
            kind_o = K_FAULT;
        end else begin
            kind_o = K_RETIRE;
        end
    end

endmodule

// File: rtl/commit_walk.sv
module commit_walk
    import commit_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int SLOTS = 6,
    localparam int NCW  = $clog2(WIDTH + 1)
) (
    input  logic             blocked_i,
    input  logic             stores_pending_i,
    input  logic [SLOTS-1:0] ready_i,
    input  head_kind_e       kind_i [SLOTS],
    output logic [SLOTS-1:0] retire_o,
    output logic [SLOTS-1:0] commit_o,
    output logic [SLOTS-1:0] serial_hit_o,
    output logic [SLOTS-1:0] uncached_hit_o,
    output logic [SLOTS-1:0] trap_hit_o,
    output logic [SLOTS-1:0] unknown_hit_o,
    output logic [NCW-1:0]   n_commit_o
);

    logic           stopped;
    logic [NCW-1:0] n;

    always_comb begin
        stopped        = blocked_i;
        n              = '0;
        retire_o       = '0;
        commit_o       = '0;
        serial_hit_o   = '0;
        uncached_hit_o = '0;
        trap_hit_o     = '0;
        unknown_hit_o  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!stopped) begin
                if (n == NCW'(WIDTH) || !ready_i[i]) begin
                    stopped = 1'b1;
                end else begin
                    unique case (kind_i[i])
                        K_SQUASHED: retire_o[i] = 1'b1;
                        K_RETIRE: begin
                            retire_o[i] = 1'b1;
                            commit_o[i] = 1'b1;
                            n           = n + 1'b1;
                        end
                        K_SERIAL: begin
                            if (n == '0 && !stores_pending_i) begin
                                serial_hit_o[i] = 1'b1;
                            end
                            stopped = 1'b1;
                        end
                        K_UNCACHED: begin
                            uncached_hit_o[i] = 1'b1;
                            stopped           = 1'b1;
                        end
                        K_FAULT: begin
                            if (n == '0 && !stores_pending_i) begin
                                trap_hit_o[i] = 1'b1;
                            end
                            stopped = 1'b1;
                        end
                        default: begin
                            unknown_hit_o[i] = 1'b1;
                            stopped          = 1'b1;
                        end
                    endcase
                end
            end
        end
        n_commit_o = n;
    end

endmodule

// File: rtl/commit_head_ctrl.sv
module commit_head_ctrl
    import commit_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter int SLOTS      = 6,
    parameter int SEQ_W      = 16,
    parameter int PC_W       = 32,
    parameter int CNT_W      = 32,
    parameter int INST_BYTES = 4,
    parameter logic [PC_W-1:0] RESET_PC = PC_W'(32'h1000)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SLOTS-1:0]        head_ready_i,
    input  logic [SLOTS*FLAG_W-1:0] head_flags_i,
    input  logic [SLOTS*SEQ_W-1:0]  head_seq_i,
    input  logic                    store_wb_pending_i,
    input  logic                    trap_clear_i,
    output logic [SLOTS-1:0]        retire_o,
    output logic [SLOTS-1:0]        clear_cancommit_o,
    output logic                    nonspec_req_o,
    output logic                    nonspec_uncached_o,
    output logic [SEQ_W-1:0]        nonspec_seq_o,
    output logic                    trap_req_o,
    output logic [SEQ_W-1:0]        trap_seq_o,
    output logic                    error_o,
    output logic                    trap_pending_o,
    output logic [PC_W-1:0]         pc_o,
    output logic [SEQ_W-1:0]        done_seq_o,
    output logic [CNT_W-1:0]        commit_count_o,
    output logic [CNT_W-1:0]        bw_limit_events_o
);

    localparam int NCW = $clog2(WIDTH + 1);

    if (WIDTH < 1 || WIDTH > 8) begin : g_bad_width
        $error("commit width must lie between 1 and 8");
    end
    if (SLOTS < WIDTH) begin : g_bad_slots
        $error("head window must be at least the commit width");
    end

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [SEQ_W-1:0] done_seq;
        logic [CNT_W-1:0] committed;
        logic [CNT_W-1:0] bw_events;
        logic             trap_pending;
    } state_t;

    state_t state_d, state_q;

    head_kind_e       kind      [SLOTS];
    logic [SLOTS-1:0] countable;
    logic [SEQ_W-1:0] seq       [SLOTS];
    logic [SLOTS-1:0] commit_mask;
    logic [SLOTS-1:0] serial_hit;
    logic [SLOTS-1:0] uncached_hit;
    logic [SLOTS-1:0] trap_hit;
    logic [SLOTS-1:0] unknown_hit;
    logic [NCW-1:0]   n_commit;
    logic [NCW-1:0]   n_counted;
    logic [SEQ_W-1:0] youngest_seq;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign seq[g] = head_seq_i[g*SEQ_W +: SEQ_W];
        head_classify u_cls (
            .flags_i     (head_flags_i[g*FLAG_W +: FLAG_W]),
            .kind_o      (kind[g]),
            .countable_o (countable[g])
        );
    end

    commit_walk #(
        .WIDTH (WIDTH),
        .SLOTS (SLOTS)
    ) u_walk (
        .blocked_i        (state_q.trap_pending),
        .stores_pending_i (store_wb_pending_i),
        .ready_i          (head_ready_i),
        .kind_i           (kind),
        .retire_o         (retire_o),
        .commit_o         (commit_mask),
        .serial_hit_o     (serial_hit),
        .uncached_hit_o   (uncached_hit),
        .trap_hit_o       (trap_hit),
        .unknown_hit_o    (unknown_hit),
        .n_commit_o       (n_commit)
    );

    // Request muxing: at most one slot can hit, since every hit ends the walk.
    always_comb begin
        nonspec_seq_o = '0;
        trap_seq_o    = '0;
        youngest_seq  = state_q.done_seq;
        n_counted     = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (serial_hit[i] || uncached_hit[i]) begin
                nonspec_seq_o = seq[i];
            end
            if (trap_hit[i]) begin
                trap_seq_o = seq[i];
            end
            if (commit_mask[i]) begin
                youngest_seq = seq[i];
                if (countable[i]) begin
                    n_counted = n_counted + 1'b1;
                end
            end
        end
    end

    assign clear_cancommit_o  = serial_hit | uncached_hit;
    assign nonspec_req_o      = |clear_cancommit_o;
    assign nonspec_uncached_o = |uncached_hit;
    assign trap_req_o         = |trap_hit;
    assign error_o            = |unknown_hit;

    always_comb begin
        state_d          = state_q;
        state_d.pc       = state_q.pc + PC_W'(n_commit) * PC_W'(INST_BYTES);
        state_d.done_seq = youngest_seq;
        state_d.committed = state_q.committed + CNT_W'(n_counted);
        if (n_commit == NCW'(WIDTH)) begin
            state_d.bw_events = state_q.bw_events + 1'b1;
        end
        if (state_q.trap_pending) begin
            state_d.trap_pending = !trap_clear_i;
        end else begin
            state_d.trap_pending = trap_req_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q              <= '0;
            state_q.pc           <= RESET_PC;
        end else begin
            state_q <= state_d;
        end
    end

    assign trap_pending_o    = state_q.trap_pending;
    assign pc_o              = state_q.pc;
    assign done_seq_o        = state_q.done_seq;
    assign commit_count_o    = state_q.committed;
    assign bw_limit_events_o = state_q.bw_events;

endmodule

// File: rtl/commit_head_ctrl_chk.sv
module commit_head_ctrl_chk #(
    parameter int WIDTH      = 4,
    parameter int SLOTS      = 6,
    parameter int PC_W       = 32,
    parameter int CNT_W      = 32,
    parameter int INST_BYTES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             store_wb_pending_i,
    input logic [SLOTS-1:0] retire_o,
    input logic [SLOTS-1:0] commit_mask,
    input logic             nonspec_req_o,
    input logic             nonspec_uncached_o,
    input logic             trap_req_o,
    input logic             error_o,
    input logic             trap_pending_o,
    input logic [PC_W-1:0]  pc_o,
    input logic [CNT_W-1:0] bw_limit_events_o
);

    int unsigned n_now;
    always_comb n_now = $countones(commit_mask);

    // R1: never more than WIDTH real commits per cycle
    a_r1_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
        n_now <= WIDTH);

    // R3: serialising request only as first commit with stores drained
    a_r3_serial_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (nonspec_req_o && !nonspec_uncached_o) |-> (!store_wb_pending_i && n_now == 0));

    // R5: trap only as first commit with stores drained
    a_r5_trap_alone: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> (!store_wb_pending_i && n_now == 0));

    // R5: trap request leaves the trap flag set
    a_r5_trap_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |=> trap_pending_o);

    // R6: pc advances by one word per commit
    a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pc_o == $past(pc_o) + PC_W'($past(n_now)) * PC_W'(INST_BYTES)));

    // R8: full-width cycles bump the event counter
    a_r8_bw_event: assert property (@(posedge clk) disable iff (!rst_n)
        (n_now == WIDTH) |=> (bw_limit_events_o == $past(bw_limit_events_o) + 1'b1));

    // R9: an outstanding trap blocks everything
    a_r9_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pending_o |-> (retire_o == '0 && !trap_req_o && !nonspec_req_o && !error_o));

    // R10: at most one special action per cycle
    a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nonspec_req_o, trap_req_o, error_o}));

endmodule

bind commit_head_ctrl commit_head_ctrl_chk #(
    .WIDTH      (WIDTH),
    .SLOTS      (SLOTS),
    .PC_W       (PC_W),
    .CNT_W      (CNT_W),
    .INST_BYTES (INST_BYTES)
) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .store_wb_pending_i (store_wb_pending_i),
    .retire_o           (retire_o),
    .commit_mask        (commit_mask),
    .nonspec_req_o      (nonspec_req_o),
    .nonspec_uncached_o (nonspec_uncached_o),
    .trap_req_o         (trap_req_o),
    .error_o            (error_o),
    .trap_pending_o     (trap_pending_o),
    .pc_o               (pc_o),
    .bw_limit_events_o  (bw_limit_events_o)
);

// File: tb/commit_head_ctrl_tb.sv
module commit_head_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W     = 4;
    localparam int S     = 6;
    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;
    localparam int CNT_W = 32;
    localparam logic [PC_W-1:0] RPC = 32'h1000;

    localparam logic [2:0] EV_NONE = 3'd0;
    localparam logic [2:0] EV_NS   = 3'd1;
    localparam logic [2:0] EV_UNC  = 3'd2;
    localparam logic [2:0] EV_TRAP = 3'd3;
    localparam logic [2:0] EV_ERR  = 3'd4;

    // kinds: one octal digit per slot, slot 5 leftmost
    // 0 normal, 1 squashed, 2 unexec nonspec, 3 unexec load,
    // 4 executed fault, 5 unexec unknown, 6 executed nop, 7 unexec membar
    typedef struct packed {
        logic [5:0]  rdy;
        logic [17:0] kinds;
        logic        stp;
        logic [5:0]  ret;
        logic [2:0]  ev;
        logic [2:0]  slot;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{6'b111111, 18'o000000, 1'b0, 6'b001111, EV_NONE, 3'd0},
        '{6'b111111, 18'o000110, 1'b0, 6'b111111, EV_NONE, 3'd0},
        '{6'b000111, 18'o000000, 1'b0, 6'b000111, EV_NONE, 3'd0},
        '{6'b111111, 18'o000002, 1'b0, 6'b000000, EV_NS,   3'd0},
        '{6'b111111, 18'o000020, 1'b0, 6'b000001, EV_NONE, 3'd0},
        '{6'b111111, 18'o000002, 1'b1, 6'b000000, EV_NONE, 3'd0},
        '{6'b111111, 18'o000021, 1'b0, 6'b000001, EV_NS,   3'd1},
        '{6'b111111, 18'o000030, 1'b1, 6'b000001, EV_UNC,  3'd1},
        '{6'b111111, 18'o000005, 1'b0, 6'b000000, EV_ERR,  3'd0},
        '{6'b111111, 18'o000060, 1'b0, 6'b001111, EV_NONE, 3'd0},
        '{6'b111111, 18'o000007, 1'b0, 6'b000000, EV_NS,   3'd0},
        '{6'b111111, 18'o000040, 1'b0, 6'b000001, EV_NONE, 3'd0},
        '{6'b000000, 18'o000000, 1'b0, 6'b000000, EV_NONE, 3'd0},
        '{6'b111011, 18'o000000, 1'b0, 6'b000011, EV_NONE, 3'd0},
        '{6'b111111, 18'o010000, 1'b0, 6'b001111, EV_NONE, 3'd0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [S-1:0]         head_ready_i;
    logic [S*10-1:0]      head_flags_i;
    logic [S*SEQ_W-1:0]   head_seq_i;
    logic                 store_wb_pending_i;
    logic                 trap_clear_i;
    logic [S-1:0]         retire_o;
    logic [S-1:0]         clear_cancommit_o;
    logic                 nonspec_req_o;
    logic                 nonspec_uncached_o;
    logic [SEQ_W-1:0]     nonspec_seq_o;
    logic                 trap_req_o;
    logic [SEQ_W-1:0]     trap_seq_o;
    logic                 error_o;
    logic                 trap_pending_o;
    logic [PC_W-1:0]      pc_o;
    logic [SEQ_W-1:0]     done_seq_o;
    logic [CNT_W-1:0]     commit_count_o;
    logic [CNT_W-1:0]     bw_limit_events_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [PC_W-1:0]  exp_pc   = RPC;
    logic [CNT_W-1:0] exp_cnt  = '0;
    logic [CNT_W-1:0] exp_bw   = '0;
    logic [SEQ_W-1:0] exp_done = '0;
    logic             exp_pend = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    commit_head_ctrl #(
        .WIDTH (W), .SLOTS (S), .SEQ_W (SEQ_W), .PC_W (PC_W),
        .CNT_W (CNT_W), .INST_BYTES (4), .RESET_PC (RPC)
    ) u_dut (.*);

    function automatic logic [9:0] code_flags(input logic [2:0] k);
        case (k)
            3'd0:    return 10'b0000000010;
            3'd1:    return 10'b0000000011;
            3'd2:    return 10'b0000001000;
            3'd3:    return 10'b0010000000;
            3'd4:    return 10'b0000000110;
            3'd6:    return 10'b0100000010;
            3'd7:    return 10'b0000100000;
            default: return 10'b0000000000;
        endcase
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Entered and left at a falling edge.
    task automatic run_case(input string tag, input logic [5:0] rdy, input logic [17:0] kinds,
                            input logic stp, input logic clr, input logic [5:0] ret,
                            input logic [2:0] ev, input logic [2:0] slot, input logic [SEQ_W-1:0] base);
        int n   = 0;
        int cnt = 0;
        int yng = -1;
        head_ready_i       = rdy;
        store_wb_pending_i = stp;
        trap_clear_i       = clr;
        for (int i = 0; i < S; i++) begin
            head_flags_i[i*10 +: 10]     = code_flags(kinds[3*i +: 3]);
            head_seq_i[i*SEQ_W +: SEQ_W] = base + SEQ_W'(i);
        end
        #1;
        chk({tag, " retire mask (R1 R2)"}, 64'(retire_o), 64'(ret));
        chk({tag, " nonspec request (R3 R4)"}, 64'(nonspec_req_o), 64'(ev == EV_NS || ev == EV_UNC));
        chk({tag, " uncached flag (R4)"}, 64'(nonspec_uncached_o), 64'(ev == EV_UNC));
        chk({tag, " clear can-commit (R3 R4)"}, 64'(clear_cancommit_o),
            (ev == EV_NS || ev == EV_UNC) ? (64'd1 << slot) : 64'd0);
        chk({tag, " trap request (R5 R9)"}, 64'(trap_req_o), 64'(ev == EV_TRAP));
        chk({tag, " error flag (R10)"}, 64'(error_o), 64'(ev == EV_ERR));
        if (ev == EV_NS || ev == EV_UNC)
            chk({tag, " request seq (R3 R4)"}, 64'(nonspec_seq_o), 64'(base + SEQ_W'(slot)));
        if (ev == EV_TRAP)
            chk({tag, " trap seq (R5)"}, 64'(trap_seq_o), 64'(base + SEQ_W'(slot)));
        for (int i = 0; i < S; i++) begin
            if (ret[i] && kinds[3*i +: 3] != 3'd1) begin
                n++;
                yng = i;
                if (kinds[3*i +: 3] != 3'd6) cnt++;
            end
        end
        exp_pc  = exp_pc + PC_W'(4 * n);
        exp_cnt = exp_cnt + CNT_W'(cnt);
        if (n == W) exp_bw = exp_bw + 1'b1;
        if (yng >= 0) exp_done = base + SEQ_W'(yng);
        exp_pend = exp_pend ? !clr : (ev == EV_TRAP);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " pc (R6)"}, 64'(pc_o), 64'(exp_pc));
        chk({tag, " done seq (R6)"}, 64'(done_seq_o), 64'(exp_done));
        chk({tag, " commit count (R7)"}, 64'(commit_count_o), 64'(exp_cnt));
        chk({tag, " bw events (R8)"}, 64'(bw_limit_events_o), 64'(exp_bw));
        chk({tag, " trap pending (R5 R9)"}, 64'(trap_pending_o), 64'(exp_pend));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n              = 1'b0;
        head_ready_i       = '0;
        head_flags_i       = '0;
        head_seq_i         = '0;
        store_wb_pending_i = 1'b0;
        trap_clear_i       = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk("reset pc (R11)", 64'(pc_o), 64'(RPC));
        chk("reset done seq (R11)", 64'(done_seq_o), 64'd0);
        chk("reset count (R11)", 64'(commit_count_o), 64'd0);
        chk("reset bw (R11)", 64'(bw_limit_events_o), 64'd0);
        chk("reset trap flag (R11)", 64'(trap_pending_o), 64'd0);

        for (int v = 0; v < NV; v++) begin
            run_case($sformatf("vec%0d", v), VEC[v].rdy, VEC[v].kinds, VEC[v].stp, 1'b0,
                     VEC[v].ret, VEC[v].ev, VEC[v].slot, SEQ_W'(16 * (v + 1)));
        end

        // R5: fault held back by pending stores
        run_case("fault stores", 6'b111111, 18'o000004, 1'b1, 1'b0, 6'b000000, EV_NONE, 3'd0, 16'h400);
        // R9: clear with nothing pending is ignored
        run_case("stray clear", 6'b111111, 18'o000004, 1'b1, 1'b1, 6'b000000, EV_NONE, 3'd0, 16'h410);
        // R5: fault taken as first commit
        run_case("fault taken", 6'b111111, 18'o000004, 1'b0, 1'b0, 6'b000000, EV_TRAP, 3'd0, 16'h420);
        // R9: blocked while the trap is pending
        run_case("blocked", 6'b111111, 18'o000000, 1'b0, 1'b0, 6'b000000, EV_NONE, 3'd0, 16'h430);
        run_case("blocked serial", 6'b111111, 18'o000002, 1'b0, 1'b0, 6'b000000, EV_NONE, 3'd0, 16'h440);
        // R9: clear cycle still blocked, flag drops after the edge
        run_case("clearing", 6'b111111, 18'o000000, 1'b0, 1'b1, 6'b000000, EV_NONE, 3'd0, 16'h450);
        run_case("resumed", 6'b111111, 18'o000000, 1'b0, 1'b0, 6'b001111, EV_NONE, 3'd0, 16'h460);
        // R2 squashed only, no width use
        run_case("all squashed", 6'b111111, 18'o111111, 1'b0, 1'b0, 6'b111111, EV_NONE, 3'd0, 16'h470);

        head_ready_i = '0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule